// File: doc/BRIEF.md
# Event timer register interface

This block is the software-visible front end of a multi-channel event timer. It holds four global registers: a fixed capabilities word, a general configuration register, a shared interrupt status register and a 32-bit main counter. It takes 4-byte and 8-byte reads and writes on a plain address/data request bus. Each access is decoded either to one of those global registers or to a window of registers owned by one timer channel. Read data is merged and returned one cycle after the request.

The comparators and interrupt delivery sit in the timer channels, outside this block. The block gives them three things. First, one-hot write and read strobes with a register code and aligned data and byte-lane mask. Second, the running count, the enable level and a pulse on each enable change. Third, a write-1-to-clear request vector for the status bits.

A small two-state machine tracks the read response. IDLE moves to RESP when a read is accepted. RESP stays in RESP while reads keep arriving back to back, and returns to IDLE on any cycle without a read. Writes are accepted in either state.

Top module: `evt_regif`

## Requirements
- R1: Only accesses of 4 or 8 bytes that are naturally aligned to their own size are legal. An illegal write changes nothing and raises no strobe. An illegal read still responds, with data zero.
- R2: A 4-byte access with address bit 2 set reaches the upper half of the 64-bit register. Write data and lane mask move up by 32 bits, and read data moves down by 32 bits.
- R3: The capabilities word at offset 0x000 is read-only. Bits 7:0 are 1. Bits 12:8 are N_TMR-1. Bit 13 is 0, meaning a 32-bit counter. Bits 31:16 are 0x8086. Bits 63:32 are 59604644, the femtosecond period of a 2^24 Hz tick. All other bits are 0.
- R4: The configuration register at 0x010 stores all written lanes, except that bit 1 always reads 0. Bit 0 enables the counter.
- R5: The main counter, readable at 0x0F0 as a zero-extended value, goes up by one on each cycle with `tick` high while bit 0 of the configuration register is set. It holds while that bit is clear, and resumes from the held value. It wraps modulo 2^32.
- R6: A write to 0x0F0 merges the written lanes into the zero-extended current count and loads the low 32 bits. A write to the upper half alone leaves the count unchanged.
- R7: The status register at 0x020 has bit i set by `irq_set[i]`. Writing ones in its low lanes clears only bits that are currently set, and pulses those bits on `clr_req` one cycle after the write. Zeros have no effect. When a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: A read of any offset not mapped to a register returns zero.
- R9: Timer i owns offsets 0x100+0x20*i. Sub-offset 0x0 has register code 0, 0x8 has code 1 and 0x10 has code 2; 0x18 is unmapped. A legal access there raises bit i of `tmr_wr` or `tmr_rd` in the request cycle, drives `tmr_reg`, and drives `tmr_wdata`/`tmr_wmask` aligned per R2. A read returns `tmr_rdata`.
- R10: After reset `rsp_valid`, `main_count`, `isr_bits`, `cnt_enabled` and the configuration register are zero. `rsp_valid` is high exactly in the cycle after each read request.
- R11: `en_toggle` pulses for one cycle after a write that changes configuration bit 0. `cnt_enabled` follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter tick enable pulse |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 64 | Write data, low-aligned |
| irq_set | input | N_TMR | Per-timer status set pulses |
| tmr_rdata | input | 64 | Read data from the selected timer register |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 64 | Read response data |
| main_count | output | 32 | Current main counter value |
| cnt_enabled | output | 1 | Counter enable level |
| en_toggle | output | 1 | Pulse after the enable bit changes |
| isr_bits | output | N_TMR | Interrupt status bits |
| clr_req | output | N_TMR | Write-1-to-clear pulse per timer |
| tmr_wr | output | N_TMR | One-hot timer register write strobe |
| tmr_rd | output | N_TMR | One-hot timer register read strobe |
| tmr_reg | output | 2 | Register code within the timer window |
| tmr_wdata | output | 64 | Aligned write data to the timer |
| tmr_wmask | output | 64 | Aligned lane mask to the timer |

## Verification
The hardest state to reach is a count that wraps, or a status bit that is cleared and set in the same cycle. Neither happens from ordinary register traffic, because the count only moves on explicit tick pulses. The bench therefore loads the counter just below 2^32 through a low-half write and then counts a known number of pulses. It also drives a set pulse in the very cycle of a clear write. A seeded random mix of widths and alignments across every region, checked against a bench-side register model, covers the half-word and illegal combinations.

// File: rtl/evt_regif_pkg.sv
package evt_regif_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_CFG,
        SEL_ISR,
        SEL_CNT,
        SEL_TMR
    } reg_sel_t;

    localparam int unsigned OFF_CAP  = 'h000;
    localparam int unsigned OFF_CFG  = 'h010;
    localparam int unsigned OFF_ISR  = 'h020;
    localparam int unsigned OFF_CNT  = 'h0F0;
    localparam int unsigned TMR_BASE = 'h100;
    localparam int unsigned TMR_STEP = 'h20;

    localparam logic [63:0] TICK_HZ = 64'd1 << 24;
    localparam logic [63:0] FS_TICK = 64'd1000000000000000 / TICK_HZ;

    localparam int unsigned CFG_EN_BIT  = 0;
    localparam int unsigned CFG_LEG_BIT = 1;

    function automatic logic [63:0] caps_word(input int unsigned n);
        return {FS_TICK[31:0], 16'h8086, 3'b000, 5'(n - 1), 8'h01};
    endfunction

endpackage

// File: rtl/evt_regif_decode.sv
module evt_regif_decode
    import evt_regif_pkg::*;
#(
    parameter int unsigned N_TMR  = 8,
    parameter int unsigned ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        size,
    input  logic [63:0]       wdata,
    output logic              legal,
    output logic              hi,
    output reg_sel_t          sel,
    output logic [N_TMR-1:0]  tmr_hit,
    output logic [1:0]        reg_code,
    output logic [63:0]       mask,
    output logic [63:0]       data
);
    localparam int unsigned WORD_W = ADDR_W - 3;
    localparam int unsigned WIN_W  = ADDR_W - 5;

    logic [WORD_W-1:0] word;
    logic              size4, size8;

    assign word  = addr[ADDR_W-1:3];
    assign size4 = (size == 4'd4);
    assign size8 = (size == 4'd8);
    assign legal = (size4 && addr[1:0] == 2'b00) || (size8 && addr[2:0] == 3'b000);
    assign hi    = size4 && addr[2];
    assign reg_code = addr[4:3];

    always_comb begin
        if (size8) begin
            mask = '1;
            data = wdata;
        end else if (hi) begin
            mask = {32'hFFFF_FFFF, 32'h0};
            data = {wdata[31:0], 32'h0};
        end else begin
            mask = {32'h0, 32'hFFFF_FFFF};
            data = wdata;
        end
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_win
        localparam int unsigned WIN = (TMR_BASE + TMR_STEP * i) / TMR_STEP;
        assign tmr_hit[i] = (addr[ADDR_W-1:5] == WIN_W'(WIN)) && (addr[4:3] != 2'b11);
    end

    always_comb begin
        sel = SEL_NONE;
        if (word == WORD_W'(OFF_CAP >> 3))      sel = SEL_CAP;
        else if (word == WORD_W'(OFF_CFG >> 3)) sel = SEL_CFG;
        else if (word == WORD_W'(OFF_ISR >> 3)) sel = SEL_ISR;
        else if (word == WORD_W'(OFF_CNT >> 3)) sel = SEL_CNT;
        else if (|tmr_hit)                      sel = SEL_TMR;
    end

endmodule

// File: rtl/evt_regif_counter.sv
module evt_regif_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)             count <= '0;
        else if (load)       count <= load_val;
        else if (en && tick) count <= count + 1'b1;
    end
endmodule

// File: rtl/evt_regif.sv
module evt_regif
    import evt_regif_pkg::*;
#(
    parameter int unsigned N_TMR  = 8,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    input  logic [N_TMR-1:0]  irq_set,
    input  logic [63:0]       tmr_rdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic [31:0]       main_count,
    output logic              cnt_enabled,
    output logic              en_toggle,
    output logic [N_TMR-1:0]  isr_bits,
    output logic [N_TMR-1:0]  clr_req,
    output logic [N_TMR-1:0]  tmr_wr,
    output logic [N_TMR-1:0]  tmr_rd,
    output logic [1:0]        tmr_reg,
    output logic [63:0]       tmr_wdata,
    output logic [63:0]       tmr_wmask
);
    localparam logic [63:0] CAPS = caps_word(N_TMR);

    typedef enum logic {ST_IDLE, ST_RESP} rsp_state_t;

    logic              acc_legal, acc_hi;
    reg_sel_t          acc_sel;
    logic [N_TMR-1:0]  acc_hit;
    logic [1:0]        acc_code;
    logic [63:0]       acc_mask, acc_data;

    evt_regif_decode #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .size(req_size), .wdata(req_wdata),
        .legal(acc_legal), .hi(acc_hi), .sel(acc_sel), .tmr_hit(acc_hit),
        .reg_code(acc_code), .mask(acc_mask), .data(acc_data)
    );

    logic wr_acc, rd_acc;
    assign wr_acc = req_valid && req_write && acc_legal;
    assign rd_acc = req_valid && !req_write;

    // configuration register
    logic [63:0] cfg_q, cfg_next;
    logic        en_tgl_q;
    always_comb begin
        cfg_next = (cfg_q & ~acc_mask) | (acc_data & acc_mask);
        cfg_next[CFG_LEG_BIT] = 1'b0;
    end
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            en_tgl_q <= 1'b0;
        end else begin
            en_tgl_q <= 1'b0;
            if (wr_acc && acc_sel == SEL_CFG) begin
                cfg_q    <= cfg_next;
                en_tgl_q <= cfg_next[CFG_EN_BIT] != cfg_q[CFG_EN_BIT];
            end
        end
    end

    // main counter
    logic        cnt_load;
    logic [63:0] cnt_merge;
    assign cnt_load  = wr_acc && acc_sel == SEL_CNT;
    assign cnt_merge = ({32'h0, main_count} & ~acc_mask) | (acc_data & acc_mask);

    evt_regif_counter #(.CNT_W(32)) u_cnt (
        .clk(clk), .rst(rst), .en(cfg_q[CFG_EN_BIT]), .tick(tick),
        .load(cnt_load), .load_val(cnt_merge[31:0]), .count(main_count)
    );

    // interrupt status, write one to clear
    logic [N_TMR-1:0] isr_q, clr_now, clr_q;
    assign clr_now = (wr_acc && acc_sel == SEL_ISR) ?
                     (isr_q & acc_data[N_TMR-1:0] & acc_mask[N_TMR-1:0]) : '0;
    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            clr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_now) | irq_set;
            clr_q <= clr_now;
        end
    end

    // read data merge
    logic [63:0] rd_full, rd_word, rdata_q;
    always_comb begin
        rd_full = '0;
        unique case (acc_sel)
            SEL_CAP:  rd_full = CAPS;
            SEL_CFG:  rd_full = cfg_q;
            SEL_ISR:  rd_full = 64'(isr_q);
            SEL_CNT:  rd_full = {32'h0, main_count};
            SEL_TMR:  rd_full = tmr_rdata;
            default:  rd_full = '0;
        endcase
        if (!acc_legal)  rd_word = '0;
        else if (acc_hi) rd_word = rd_full >> 32;
        else             rd_word = rd_full;
    end

    // response state machine: state register
    rsp_state_t st_q, st_d;
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (rd_acc)  st_d = ST_RESP;
            ST_RESP: if (!rd_acc) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (rd_acc) rdata_q <= rd_word;
        end
    end

    // outputs
    always_comb begin
        rsp_valid   = (st_q == ST_RESP);
        rsp_rdata   = rdata_q;
        cnt_enabled = cfg_q[CFG_EN_BIT];
        en_toggle   = en_tgl_q;
        isr_bits    = isr_q;
        clr_req     = clr_q;
        tmr_wr      = (wr_acc && acc_sel == SEL_TMR) ? acc_hit : '0;
        tmr_rd      = (rd_acc && acc_legal && acc_sel == SEL_TMR) ? acc_hit : '0;
        tmr_reg     = acc_code;
        tmr_wdata   = acc_data;
        tmr_wmask   = acc_mask;
    end

endmodule

// File: rtl/evt_regif_chk.sv
module evt_regif_chk #(
    parameter int unsigned N_TMR = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_write,
    input logic             acc_legal,
    input logic             rsp_valid,
    input logic [63:0]      cfg_q,
    input logic [31:0]      main_count,
    input logic             cnt_load,
    input logic [N_TMR-1:0] isr_q,
    input logic [N_TMR-1:0] clr_req,
    input logic             en_toggle,
    input logic [N_TMR-1:0] tmr_wr,
    input logic [N_TMR-1:0] tmr_rd
);
    // R10
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);
    // R10
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
    // R1
    illegal_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !acc_legal) |=> $stable(cfg_q));
    // R4
    legacy_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[1]);
    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q[0] && !cnt_load) |=> $stable(main_count));
    // R7
    clear_only_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|clr_req) |-> ((clr_req & ~$past(isr_q)) == '0));
    // R11
    toggle_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        en_toggle |-> (cfg_q[0] != $past(cfg_q[0])));
    // R9
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tmr_wr) && $onehot0(tmr_rd));
endmodule

bind evt_regif evt_regif_chk #(.N_TMR(N_TMR)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .acc_legal(acc_legal), .rsp_valid(rsp_valid), .cfg_q(cfg_q),
    .main_count(main_count), .cnt_load(cnt_load), .isr_q(isr_q),
    .clr_req(clr_req), .en_toggle(en_toggle), .tmr_wr(tmr_wr), .tmr_rd(tmr_rd)
);

// File: tb/evt_regif_test.sv
module evt_regif_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned N_TMR  = 8;
    localparam int unsigned ADDR_W = 10;

    logic              clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd8;
    logic [63:0]       req_wdata = '0;
    logic [N_TMR-1:0]  irq_set = '0;
    logic [63:0]       tmr_rdata;
    logic              rsp_valid, cnt_enabled, en_toggle;
    logic [63:0]       rsp_rdata, tmr_wdata, tmr_wmask;
    logic [31:0]       main_count;
    logic [N_TMR-1:0]  isr_bits, clr_req, tmr_wr, tmr_rd;
    logic [1:0]        tmr_reg;

    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    evt_regif #(.N_TMR(N_TMR), .ADDR_W(ADDR_W)) uut (.*);

    // timer channel stand-in: data identifies channel and register
    assign tmr_rdata = {24'hC0DE00, tmr_rd, 30'd0, tmr_reg};

    // bench register model
    logic [63:0]      m_cfg = '0;
    logic [N_TMR-1:0] m_isr = '0;
    logic [31:0]      m_cnt = '0;

    function automatic bit f_legal(input int unsigned a, input int unsigned s);
        return (s == 4 && (a % 4) == 0) || (s == 8 && (a % 8) == 0);
    endfunction

    function automatic logic [63:0] f_caps();
        logic [63:0] c = 64'd59604644 << 32;
        c[31:16] = 16'h8086;
        c[12:8]  = 5'(N_TMR - 1);
        c[7:0]   = 8'd1;
        return c;
    endfunction

    function automatic logic [63:0] f_read(input int unsigned a, input int unsigned s);
        logic [63:0] v;
        int unsigned base = a & ~32'd7;
        if (!f_legal(a, s)) return '0;
        v = '0;
        if (base == 'h000) v = f_caps();
        else if (base == 'h010) v = m_cfg;
        else if (base == 'h020) v = 64'(m_isr);
        else if (base == 'h0F0) v = {32'h0, m_cnt};
        else if (base >= 'h100 && base < 'h100 + 'h20 * N_TMR && ((base >> 3) % 4) != 3)
            v = {24'hC0DE00, 8'(1 << ((base - 'h100) / 'h20)), 30'd0, 2'((base >> 3) % 4)};
        if (s == 4 && a[2]) v = v >> 32;
        return v;
    endfunction

    function automatic logic [63:0] f_mask(input int unsigned a, input int unsigned s);
        if (s == 8) return '1;
        return a[2] ? 64'hFFFF_FFFF_0000_0000 : 64'h0000_0000_FFFF_FFFF;
    endfunction

    function automatic logic [63:0] f_data(input int unsigned a, input int unsigned s, input logic [63:0] d);
        return (s == 4 && a[2]) ? {d[31:0], 32'h0} : d;
    endfunction

    task automatic m_write(input int unsigned a, input int unsigned s, input logic [63:0] d);
        logic [63:0] mk, dd, t;
        int unsigned base = a & ~32'd7;
        if (!f_legal(a, s)) return;
        mk = f_mask(a, s);
        dd = f_data(a, s, d);
        if (base == 'h010) begin
            m_cfg = (m_cfg & ~mk) | (dd & mk);
            m_cfg[1] = 1'b0;
        end else if (base == 'h020) begin
            m_isr = m_isr & ~(dd[N_TMR-1:0] & mk[N_TMR-1:0]);
        end else if (base == 'h0F0) begin
            t = ({32'h0, m_cnt} & ~mk) | (dd & mk);
            m_cnt = t[31:0];
        end
    endtask

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int unsigned a, input int unsigned s, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        req_addr = ADDR_W'(a); req_size = 4'(s); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        m_write(a, s, d);
    endtask

    task automatic do_read(input int unsigned a, input int unsigned s, output logic [63:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        req_addr = ADDR_W'(a); req_size = 4'(s);
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    task automatic read_check(input string req, input int unsigned a, input int unsigned s);
        logic [63:0] d;
        logic v;
        do_read(a, s, d, v);
        check(req, $sformatf("rsp_valid @%h/%0d", a, s), 64'(v), 64'd1);
        check(req, $sformatf("rdata @%h/%0d", a, s), d, f_read(a, s));
    endtask

    task automatic pulse_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (m_cfg[0]) m_cnt = m_cnt + 1;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] d;
        logic v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", "rsp_valid after reset", 64'(rsp_valid), 0);
        check("R10", "count after reset", 64'(main_count), 0);
        check("R10", "isr after reset", 64'(isr_bits), 0);
        check("R10", "enable after reset", 64'(cnt_enabled), 0);
        read_check("R10", 'h010, 8);
        @(negedge clk);
        check("R10", "rsp_valid drops", 64'(rsp_valid), 0);

        // R3 capabilities, R2 halves
        read_check("R3", 'h000, 8);
        check("R3", "caps constant", f_read('h000, 8), 64'h038D_7EA4_8086_0701);
        read_check("R2", 'h004, 4);
        read_check("R2", 'h000, 4);
        do_write('h000, 8, '1);
        read_check("R3", 'h000, 8);

        // R4 config, R11 toggle
        do_write('h010, 8, '1);
        check("R11", "en_toggle on enable", 64'(en_toggle), 1);
        check("R11", "cnt_enabled", 64'(cnt_enabled), 1);
        read_check("R4", 'h010, 8);
        check("R4", "legacy bit model", f_read('h010, 8), 64'hFFFF_FFFF_FFFF_FFFD);
        check("R11", "en_toggle one cycle", 64'(en_toggle), 0);
        do_write('h014, 4, 64'h0);
        check("R11", "no toggle upper write", 64'(en_toggle), 0);
        read_check("R2", 'h010, 8);

        // R5 counting, hold, resume
        pulse_ticks(37);
        check("R5", "count after 37", 64'(main_count), 37);
        do_write('h010, 4, 64'h0);
        check("R11", "en_toggle on disable", 64'(en_toggle), 1);
        pulse_ticks(10);
        check("R5", "held while off", 64'(main_count), 37);
        do_write('h010, 4, 64'h1);
        pulse_ticks(5);
        check("R5", "resumed", 64'(main_count), 42);
        read_check("R5", 'h0F0, 8);

        // R6 counter load and wrap
        do_write('h0F0, 4, 64'hFFFF_FFF0);
        read_check("R6", 'h0F0, 8);
        pulse_ticks(20);
        check("R5", "wrap", 64'(main_count), 4);
        do_write('h0F4, 4, 64'h1234_5678);
        check("R6", "upper half write", 64'(main_count), 4);
        read_check("R6", 'h0F4, 4);
        do_write('h0F0, 8, 64'hAAAA_BBBB_0000_0100);
        check("R6", "8-byte load", 64'(main_count), 64'h100);

        // R1 illegal accesses
        do_write('h010, 2, 64'h0);
        do_write('h012, 4, 64'h0);
        do_write('h014, 8, 64'h0);
        check("R1", "enable kept", 64'(cnt_enabled), 1);
        read_check("R1", 'h010, 8);
        read_check("R1", 'h012, 4);
        read_check("R1", 'h004, 8);
        read_check("R1", 'h000, 2);
        do_write('h124, 8, '1);
        check("R1", "no timer strobe", 64'(tmr_wr), 0);

        // R7 status
        @(negedge clk) irq_set = 8'hA5;
        @(negedge clk) irq_set = 8'h00;
        m_isr = 8'hA5;
        check("R7", "isr set", 64'(isr_bits), 64'hA5);
        do_write('h020, 4, 64'h0F);
        check("R7", "clr_req only set bits", 64'(clr_req), 64'h05);
        check("R7", "isr after clear", 64'(isr_bits), 64'hA0);
        do_write('h024, 4, 64'hFF);
        check("R7", "upper half no clear", 64'(isr_bits), 64'hA0);
        check("R7", "no clr pulse", 64'(clr_req), 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 'h020; req_size = 4'd8;
        req_wdata = 64'h80; irq_set = 8'h80;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; irq_set = 8'h00;
        check("R7", "set wins over clear", 64'(isr_bits), 64'hA0);
        read_check("R7", 'h020, 8);

        // R8 unmapped
        read_check("R8", 'h008, 8);
        read_check("R8", 'h0E0, 8);
        read_check("R8", 'h118, 8);
        read_check("R8", 'h300, 4);

        // R9 timer strobes
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 'h12C; req_size = 4'd4;
        req_wdata = 64'h0000_0000_DEAD_BEEF;
        #1;
        check("R9", "tmr_wr one-hot", 64'(tmr_wr), 64'h02);
        check("R9", "tmr_reg", 64'(tmr_reg), 1);
        check("R9", "tmr_wmask", tmr_wmask, 64'hFFFF_FFFF_0000_0000);
        check("R9", "tmr_wdata", tmr_wdata, 64'hDEAD_BEEF_0000_0000);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        read_check("R9", 'h1F0, 8);
        read_check("R9", 'h100, 4);
        read_check("R9", 'h164, 4);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int unsigned reg_kind = $urandom_range(0, 5);
            int unsigned s = ($urandom_range(0, 3) == 0) ? 2 : (($urandom_range(0, 1) == 1) ? 8 : 4);
            int unsigned a;
            logic [63:0] wd;
            case (reg_kind)
                0: a = 'h000;
                1: a = 'h010;
                2: a = 'h020;
                3: a = 'h0F0;
                4: a = 'h100 + 'h20 * $urandom_range(0, N_TMR - 1) + 8 * $urandom_range(0, 3);
                default: a = 'h040;
            endcase
            a = a + 4 * $urandom_range(0, 1) + (($urandom_range(0, 7) == 0) ? 2 : 0);
            wd = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) do_write(a, s, wd);
            else begin
                do_read(a, s, d, v);
                check("R1", $sformatf("random rsp @%h/%0d", a, s), 64'(v), 1);
                check("R2", $sformatf("random rdata @%h/%0d", a, s), d, f_read(a, s));
            end
        end
        check("R5", "count after random", 64'(main_count), 64'(m_cnt));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule